// File: doc/BRIEF.md
# Serial Audio Bitstream Receiver

This block takes a serial bitstream from an external sender. The stream is either compressed audio or PCM samples. It arrives as a data line qualified by a sender-driven strobe, with an optional word clock. All three inputs are synchronised into the system clock domain. The block finds the active strobe edges, packs the sampled bits into bytes, most significant bit first, and pushes the bytes into a 16-entry byte FIFO. The downstream logic drains the FIFO through a show-ahead read port.

A six-bit configuration register selects one of two modes:
- **Free mode** ignores the word clock and forms a byte from every eight bits.
- **Framed mode** suits converter or digital-audio-receiver sources. Every word-clock transition starts a new word, so byte packing restarts there. Bits left over at the end of a slot are discarded. At most two bytes (16 bits) of each word are kept. Optionally, only one channel is kept, and the boundary can be moved one bit later for delayed PCM framing.

A flow-control output tells the sender when to stop. It drops early enough that the bits still in flight after it drops (23 at most) fit in the FIFO. The system clock must run at least four times faster than the strobe.

The packer is a four-state machine:
- **FREE** (free mode).
- **HUNT** (framed, waiting for the first word boundary).
- **KEEP** (framed, packing a slot that is kept).
- **SKIP** (framed, discarding a slot).

Its transitions are as follows:
- mode-bit clear sends any state to FREE.
- mode-bit set moves FREE to HUNT.
- a word boundary moves HUNT, KEEP or SKIP to KEEP when the new slot is kept, and to SKIP otherwise.

Top module: `serial_bitstream_rx`

## Requirements
- R1: The configuration register uses the following bit positions:
  - bit 0: delay the word boundary by one bit.
  - bit 1: the word-clock level that marks the kept channel.
  - bit 2: sample on the falling strobe edge in framed mode.
  - bit 3: keep all slots.
  - bit 4: framed mode.
  - bit 5: flow control active-low.

  With bit 4 clear (free mode), the word clock is ignored. Data is sampled on rising strobe edges, and each group of eight bits forms one byte, first bit in bit 7.
- R2: With bit 5 clear, `req_o` is high when more data may be sent. With bit 5 set, `req_o` is low when more data may be sent.
- R3: Flow control is active while the FIFO holds 12 bytes or fewer, and inactive while it holds 13 or more. This leaves 3 bytes of room for the 23-bit allowance after deassertion.
- R4: Bytes sent after flow control goes inactive, up to a full FIFO of 16, are all stored. They are read back in arrival order, with `rd_valid_o` high whenever a byte is available.
- R5: In framed mode (bit 4 set), any word-clock transition starts a new word, and the bit sampled at that edge is the word's first bit. Bits received before the first transition after entering framed mode are dropped.
- R6: With bit 3 clear, only words whose word-clock level equals bit 1 are stored. With bit 3 set, words on both levels are stored.
- R7: With bits 4 and 2 set, data and word clock are sampled on falling strobe edges.
- R8: Bits of a slot that do not complete a byte before the next boundary are dropped. In a 12-bit word, only the first byte is stored.
- R9: At most two bytes per word are stored. The trailing 8 bits of a 24-bit word are dropped.
- R10: With bits 4 and 0 set, the first bit of a word is the bit sampled one strobe after the word-clock transition. The bit sampled at the transition belongs to the previous word.
- R11: After reset, the configuration is 0, the FIFO is empty and `req_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sin_i | input | 1 | Serial data from the sender |
| dstr_i | input | 1 | Data strobe from the sender |
| lrclk_i | input | 1 | Word clock from the sender |
| req_o | output | 1 | Flow control to the sender, polarity set by configuration bit 5 |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_wdata_i | input | 6 | Configuration write data |
| rd_en_i | input | 1 | Pops the head byte when `rd_valid_o` is high |
| rd_data_o | output | 8 | Head byte of the FIFO |
| rd_valid_o | output | 1 | FIFO is not empty |

## Verification
A byte becomes visible on `rd_valid_o` and `rd_data_o` four system clocks after the active strobe edge that carries its last bit. The sequence is:
- two clocks in the synchroniser;
- one clock for the packer's registered push;
- one clock for the FIFO write.

`req_o` follows the FIFO count in the same cycle as that write. The bench ends each bit 4 clocks after its active edge and then waits 10 more clocks before sampling on a falling clock edge. Every result is therefore read well after it is due and long before the next stimulus. Dropped bits are checked through the empty FIFO or through the exact byte sequence read back.

// File: rtl/sbi_pkg.sv
`timescale 1ns/1ps
package sbi_pkg;

    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_HUNT = 2'd1,
        ST_KEEP = 2'd2,
        ST_SKIP = 2'd3
    } rx_state_t;

    // Bit order (MSB..LSB) matches the configuration word: 5..0
    typedef struct packed {
        logic req_low;
        logic framed;
        logic all_slots;
        logic fall_edge;
        logic left_level;
        logic lr_delay;
    } rx_cfg_t;

    localparam int CFG_W = 6;

endpackage

// File: rtl/sbi_sync_edge.sv
`timescale 1ns/1ps
module sbi_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dstr_i,
    input  logic lr_i,
    input  logic sin_i,
    output logic rise_o,
    output logic fall_o,
    output logic lr_o,
    output logic sin_o
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] stage_q [SYNC_STAGES];
    logic            dstr_prev_q;
    logic [NSIG-1:0] last_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= {dstr_i, lr_i, sin_i};
            for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign last_w = stage_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dstr_prev_q <= 1'b0;
        else        dstr_prev_q <= last_w[2];
    end

    assign rise_o = last_w[2] & ~dstr_prev_q;
    assign fall_o = ~last_w[2] & dstr_prev_q;
    assign lr_o   = last_w[1];
    assign sin_o  = last_w[0];

endmodule

// File: rtl/sbi_framer.sv
`timescale 1ns/1ps
module sbi_framer
    import sbi_pkg::*;
#(
    parameter int BYTES_PER_WORD = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  rx_cfg_t         cfg,
    input  logic            bit_ev,
    input  logic            bit_d,
    input  logic            lr_d,
    output logic            push_o,
    output logic [7:0]      push_data_o,
    output rx_state_t       state_o
);
    localparam int BCW = $clog2(BYTES_PER_WORD + 1);
    localparam logic [BCW-1:0] BPW = BCW'(BYTES_PER_WORD);

    rx_state_t       state_q, state_d;
    logic [6:0]      shreg_q, shreg_d;
    logic [2:0]      bitcnt_q, bitcnt_d;
    logic [BCW-1:0]  bytecnt_q, bytecnt_d;
    logic            lr_prev_q, pend_q;
    logic            push_q, push_d;
    logic [7:0]      pdata_q;

    logic edge_now, boundary, keep_slot, byte_done;

    assign edge_now  = bit_ev && (lr_d != lr_prev_q);
    assign boundary  = cfg.lr_delay ? (bit_ev && pend_q) : edge_now;
    assign keep_slot = cfg.all_slots || (lr_d == cfg.left_level);
    assign byte_done = bit_ev && (bitcnt_q == 3'd7);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE: if (cfg.framed) state_d = ST_HUNT;
            ST_HUNT, ST_KEEP, ST_SKIP: begin
                if (!cfg.framed)   state_d = ST_FREE;
                else if (boundary) state_d = keep_slot ? ST_KEEP : ST_SKIP;
            end
            default: state_d = ST_FREE;
        endcase
    end

    // output / datapath logic
    always_comb begin
        shreg_d   = shreg_q;
        bitcnt_d  = bitcnt_q;
        bytecnt_d = bytecnt_q;
        push_d    = 1'b0;
        unique case (state_q)
            ST_FREE: begin
                if (cfg.framed) begin
                    bitcnt_d = '0;
                end else if (bit_ev) begin
                    shreg_d  = {shreg_q[5:0], bit_d};
                    bitcnt_d = bitcnt_q + 3'd1;
                    push_d   = byte_done;
                end
            end
            ST_HUNT, ST_SKIP: begin
                if (!cfg.framed) begin
                    bitcnt_d = '0;
                end else if (boundary) begin
                    shreg_d   = {6'b0, bit_d};
                    bitcnt_d  = 3'd1;
                    bytecnt_d = '0;
                end
            end
            ST_KEEP: begin
                if (!cfg.framed) begin
                    bitcnt_d = '0;
                end else if (boundary) begin
                    shreg_d   = {6'b0, bit_d};
                    bitcnt_d  = 3'd1;
                    bytecnt_d = '0;
                end else if (bit_ev) begin
                    shreg_d  = {shreg_q[5:0], bit_d};
                    bitcnt_d = bitcnt_q + 3'd1;
                    if (byte_done && (bytecnt_q < BPW)) begin
                        push_d    = 1'b1;
                        bytecnt_d = bytecnt_q + 1'b1;
                    end
                end
            end
            default: bitcnt_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            bitcnt_q  <= '0;
            bytecnt_q <= '0;
            lr_prev_q <= 1'b0;
            pend_q    <= 1'b0;
            push_q    <= 1'b0;
            pdata_q   <= '0;
        end else begin
            shreg_q   <= shreg_d;
            bitcnt_q  <= bitcnt_d;
            bytecnt_q <= bytecnt_d;
            push_q    <= push_d;
            if (push_d) pdata_q <= {shreg_q, bit_d};
            if (bit_ev) begin
                lr_prev_q <= lr_d;
                pend_q    <= edge_now;
            end
        end
    end

    assign push_o      = push_q;
    assign push_data_o = pdata_q;
    assign state_o     = state_q;

endmodule

// File: rtl/sbi_fifo.sv
`timescale 1ns/1ps
module sbi_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [WIDTH-1:0]           wdata,
    input  logic                       pop,
    output logic [WIDTH-1:0]           rdata,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW-1:0]    wptr_q, rptr_q;
    logic [CW-1:0]    cnt_q;
    logic             do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wptr_q] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wptr_q <= (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
            if (do_pop)  rptr_q <= (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign rdata = mem_q[rptr_q];
    assign count = cnt_q;

endmodule

// File: rtl/serial_bitstream_rx.sv
`timescale 1ns/1ps
module serial_bitstream_rx
    import sbi_pkg::*;
#(
    parameter int FIFO_DEPTH     = 16,
    parameter int SLACK_BITS     = 23,
    parameter int BYTES_PER_WORD = 2,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sin_i,
    input  logic       dstr_i,
    input  logic       lrclk_i,
    output logic       req_o,
    input  logic       cfg_we_i,
    input  logic [5:0] cfg_wdata_i,
    input  logic       rd_en_i,
    output logic [7:0] rd_data_o,
    output logic       rd_valid_o
);
    // bits still in flight plus a partly filled byte, in whole bytes
    localparam int SLACK_BYTES = (SLACK_BITS + 7) / 8;
    localparam int REQ_LIMIT   = FIFO_DEPTH - SLACK_BYTES;
    localparam int CNT_W       = $clog2(FIFO_DEPTH + 1);

    rx_cfg_t    cfg_q;
    logic       rise_w, fall_w, lr_w, sin_w, bit_ev_w;
    logic       push_w, full_w, empty_w;
    logic [7:0] push_data_w;
    logic [CNT_W-1:0] count_w;
    rx_state_t  state_w;
    logic       req_act_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cfg_q <= '0;
        else if (cfg_we_i) cfg_q <= rx_cfg_t'(cfg_wdata_i);
    end

    sbi_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .dstr_i (dstr_i),
        .lr_i   (lrclk_i),
        .sin_i  (sin_i),
        .rise_o (rise_w),
        .fall_o (fall_w),
        .lr_o   (lr_w),
        .sin_o  (sin_w)
    );

    assign bit_ev_w = (cfg_q.framed && cfg_q.fall_edge) ? fall_w : rise_w;

    sbi_framer #(.BYTES_PER_WORD(BYTES_PER_WORD)) u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg         (cfg_q),
        .bit_ev      (bit_ev_w),
        .bit_d       (sin_w),
        .lr_d        (lr_w),
        .push_o      (push_w),
        .push_data_o (push_data_w),
        .state_o     (state_w)
    );

    sbi_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_w),
        .wdata (push_data_w),
        .pop   (rd_en_i),
        .rdata (rd_data_o),
        .empty (empty_w),
        .full  (full_w),
        .count (count_w)
    );

    assign req_act_w  = (count_w < CNT_W'(REQ_LIMIT));
    assign req_o      = req_act_w ^ cfg_q.req_low;
    assign rd_valid_o = !empty_w;

endmodule

// File: rtl/sbi_checker.sv
`timescale 1ns/1ps
module sbi_checker
    import sbi_pkg::*;
#(
    parameter int CW    = 5,
    parameter int DEPTH = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push,
    input logic          full,
    input logic          bit_ev,
    input logic          rd_en,
    input logic          rd_valid,
    input logic          req_o,
    input logic          cfg_we,
    input logic [5:0]    cfg,
    input logic [CW-1:0] cnt,
    input rx_state_t     st
);

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    assert_pop_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_valid && !push) |=> (cnt == $past(cnt) - 1'b1));

    assert_push_on_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> $past(bit_ev));

    assert_full_stops_sender_R3: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (req_o == cfg[5]));

    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg));

    assert_hunt_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HUNT) |=> !push);

    assert_skip_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP) |=> !push);

endmodule

bind serial_bitstream_rx sbi_checker #(.CW(CNT_W), .DEPTH(FIFO_DEPTH)) u_sbi_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push_w),
    .full     (full_w),
    .bit_ev   (bit_ev_w),
    .rd_en    (rd_en_i),
    .rd_valid (rd_valid_o),
    .req_o    (req_o),
    .cfg_we   (cfg_we_i),
    .cfg      (cfg_q),
    .cnt      (count_w),
    .st       (state_w)
);

// File: tb/serial_bitstream_rx_bench.sv
`timescale 1ns/1ps
module serial_bitstream_rx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sin = 1'b0, dstr = 1'b0, lrclk = 1'b0;
    logic       req;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_wdata = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid;

    int  errs = 0;
    int  checks = 0;
    bit  fall_mode = 1'b0;
    logic lr_cur = 1'b0;

    always #4 clk = ~clk;

    serial_bitstream_rx u_serial_bitstream_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sin_i       (sin),
        .dstr_i      (dstr),
        .lrclk_i     (lrclk),
        .req_o       (req),
        .cfg_we_i    (cfg_we),
        .cfg_wdata_i (cfg_wdata),
        .rd_en_i     (rd_en),
        .rd_data_o   (rd_data),
        .rd_valid_o  (rd_valid)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic settle();
        repeat (10) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [5:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        settle();
    endtask

    task automatic send_bit(input logic b, input logic l);
        if (!fall_mode) begin
            dstr = 1'b0; sin = b; lrclk = l; #32;
            dstr = 1'b1; #32;
        end else begin
            dstr = 1'b1; sin = b; lrclk = l; #32;
            dstr = 1'b0; #32;
        end
        lr_cur = l;
    endtask

    task automatic send_word(input logic [31:0] v, input int n, input logic l);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i], l);
    endtask

    task automatic pop_expect(input string tag, input logic [7:0] exp);
        @(negedge clk);
        check({tag, " valid"}, {31'b0, rd_valid}, 32'd1);
        check({tag, " data"}, {24'b0, rd_data}, {24'b0, exp});
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic expect_empty(input string tag);
        settle();
        check({tag, " empty"}, {31'b0, rd_valid}, 32'd0);
    endtask

    // R11: reset state
    task automatic t_reset();
        settle();
        check("R11 valid after reset", {31'b0, rd_valid}, 32'd0);
        check("R11 req after reset", {31'b0, req}, 32'd1);
    endtask

    // R1: free mode, word clock toggles but is ignored
    task automatic t_free();
        logic [7:0] a = 8'hA5, b = 8'h3C;
        for (int i = 7; i >= 0; i--) send_bit(a[i], i[0]);
        for (int i = 7; i >= 0; i--) send_bit(b[i], ~i[0]);
        settle();
        pop_expect("R1 byte0", 8'hA5);
        pop_expect("R1 byte1", 8'h3C);
        expect_empty("R1");
    endtask

    // R2, R3, R4: flow-control threshold, polarity, slack
    task automatic t_flow();
        for (int i = 0; i < 12; i++) send_word(32'h10 + i, 8, lr_cur);
        settle();
        check("R3 req at 12", {31'b0, req}, 32'd1);
        send_word(32'h1C, 8, lr_cur);
        settle();
        check("R3 req at 13", {31'b0, req}, 32'd0);
        for (int i = 13; i < 16; i++) send_word(32'h10 + i, 8, lr_cur);
        settle();
        write_cfg(6'd32);
        check("R2 inactive active-low", {31'b0, req}, 32'd1);
        for (int i = 0; i < 4; i++) pop_expect("R4 slack", 8'h10 + 8'(i));
        settle();
        check("R2 active active-low", {31'b0, req}, 32'd0);
        write_cfg(6'd0);
        check("R2 active active-high", {31'b0, req}, 32'd1);
        for (int i = 4; i < 16; i++) pop_expect("R4 order", 8'h10 + 8'(i));
        expect_empty("R4");
    endtask

    // R5: hunt then framed words, all slots
    task automatic t_framed();
        logic l;
        write_cfg(6'd24);
        for (int i = 0; i < 10; i++) send_bit(i[0], lr_cur);
        expect_empty("R5 hunt drops");
        l = ~lr_cur;
        send_word(32'h1234, 16, l);
        send_word(32'hABCD, 16, ~l);
        settle();
        pop_expect("R5 w0b0", 8'h12);
        pop_expect("R5 w0b1", 8'h34);
        pop_expect("R5 w1b0", 8'hAB);
        pop_expect("R5 w1b1", 8'hCD);
        expect_empty("R5");
    endtask

    // R6: one channel only (level 1 kept)
    task automatic t_channel();
        write_cfg(6'd18);
        for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
        send_word(32'hC301, 16, 1'b1);
        send_word(32'h7788, 16, 1'b0);
        send_word(32'h9E42, 16, 1'b1);
        settle();
        pop_expect("R6 k0", 8'hC3);
        pop_expect("R6 k1", 8'h01);
        pop_expect("R6 k2", 8'h9E);
        pop_expect("R6 k3", 8'h42);
        expect_empty("R6 other channel dropped");
    endtask

    // R7, R8: falling edge, 12-bit words (config 14 + framed)
    task automatic t_short_slot();
        logic l;
        write_cfg(6'd30);
        fall_mode = 1'b1;
        l = ~lr_cur;
        send_word(32'hB75, 12, l);
        send_word(32'h3CA, 12, ~l);
        send_word(32'hE10, 12, l);
        settle();
        pop_expect("R7 R8 s0", 8'hB7);
        pop_expect("R7 R8 s1", 8'h3C);
        pop_expect("R7 R8 s2", 8'hE1);
        expect_empty("R8 leftovers dropped");
        fall_mode = 1'b0;
    endtask

    // R9: 24-bit words keep two bytes
    task automatic t_long_word();
        logic l;
        write_cfg(6'd24);
        l = ~lr_cur;
        send_word(32'h112233, 24, l);
        send_word(32'h445566, 24, ~l);
        settle();
        pop_expect("R9 a0", 8'h11);
        pop_expect("R9 a1", 8'h22);
        pop_expect("R9 b0", 8'h44);
        pop_expect("R9 b1", 8'h55);
        expect_empty("R9 low byte dropped");
    endtask

    // R10: boundary delayed by one bit
    task automatic t_delayed();
        logic l;
        logic [15:0] a = 16'h6D2B, b = 16'h0F96;
        write_cfg(6'd25);
        l = lr_cur;
        for (int i = 0; i < 3; i++) send_bit(1'b1, l);
        send_bit(1'b0, ~l);
        for (int i = 15; i >= 1; i--) send_bit(a[i], ~l);
        send_bit(a[0], l);
        for (int i = 15; i >= 1; i--) send_bit(b[i], l);
        send_bit(b[0], ~l);
        settle();
        pop_expect("R10 a0", 8'h6D);
        pop_expect("R10 a1", 8'h2B);
        pop_expect("R10 b0", 8'h0F);
        pop_expect("R10 b1", 8'h96);
        expect_empty("R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_free();
        t_flow();
        t_framed();
        t_channel();
        t_short_slot();
        t_long_word();
        t_delayed();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        errs++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule